// File: doc/BRIEF.md
# Multi-Mode Quadrature Phase Counter

This block turns a pair of encoder signals, A and B, into a 16-bit signed-direction position count. A small register interface selects one of three decoding schemes at run time: full four-edge quadrature, step-plus-direction, and two-edge counting on B transitions only. An optional upper limit, the ceiling, bounds the count. When clearing on the ceiling is selected, an up step from the ceiling returns the count to zero and a down step from zero loads the ceiling. Otherwise the count wraps over the full 16-bit range.

Both encoder inputs pass through a two-flop synchroniser and a previous-value register before they are decoded. A start register is shared by several channels, one bit each; this instance answers to the bit at position `CH_INDEX`. A status register reports the direction of the last counted step. Software reads and writes through a single-cycle port. The read data is a combinational function of the address. A write takes effect at the next rising clock edge.

Address map: 0 count, 1 ceiling, 2 mode, 3 control, 4 status, 5 start.

Top module: `quad_phase_counter`

## Requirements
- R1: The count (address 0) resets to 0 and reads back any value written to it.
- R2: The mode register (address 2, 8 bits, reset value 4) is decoded only through its low 4 bits.
  - Code 4 selects x4 quadrature.
  - Code 5 selects step/direction.
  - Code 7 selects x2 on B.
  - Bits [7:4] do not affect decoding.
- R3: In mode 4, a change of exactly one of A or B moves the count by one. The phase sequence {A,B} = 00,10,11,01 counts up and the reverse counts down. A simultaneous change of both inputs is not counted.
- R4: In mode 5, only a rising edge of A counts: up when B is 1, down when B is 0. Edges on B never change the count.
- R5: In mode 7, every edge of B counts. The count goes up when A equals the new level of B, and down otherwise. Edges on A alone never change the count.
- R6: Control bits [2:0] select the clear source; code 1 selects the ceiling. The ceiling is at address 1, and control resets to 1 and the ceiling to 0xFFFF.
  - With code 1 selected, an up step while the count equals the ceiling gives 0.
  - With any other code, the count wraps from 0xFFFF to 0.
- R7: A down step from 0 loads the ceiling when control code 1 is selected, and 0xFFFF otherwise.
- R8: Status bit 7 (address 4) shows the direction of the last counted step: 1 for up, 0 for down. It resets to 0. Writes to the status address have no effect.
- R9: Start register bit `CH_INDEX` (address 5, reset 0) enables counting. While that bit is 0, the count holds its value.
- R10: Mode codes other than 4, 5 and 7 (in the low nibble) hold the count unchanged.
- R11: A write to the count in the same cycle as a count event stores the written value, and the event is dropped.
- R12: An input change that is stable before rising edge k shows in the count after rising edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder signal A, asynchronous |
| enc_b | input | 1 | Encoder signal B, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| count_o | output | 16 | Current count |
| dir_up_o | output | 1 | Direction of the last counted step |

## Verification
A corrupted synchroniser or previous-value stage shows up as a count that is off by one, or that moves one cycle early or late. The behavioural model compares the count on every cycle, so such a fault is reported within three clocks of the encoder edge that exposes it. A wrong decode in one mode appears as a count moving on an edge that R4 or R5 says must be ignored. A wrong clear or wrap rule appears as a value other than 0, the ceiling or 0xFFFF at the boundary step. A faulty direction register appears in `dir_up_o` and in the status read on the step that follows.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  // decoding scheme codes held in the low nibble of the mode register
  localparam logic [3:0] MODE_X4  = 4'd4;
  localparam logic [3:0] MODE_PD  = 4'd5;
  localparam logic [3:0] MODE_X2B = 4'd7;

  // register addresses
  localparam logic [2:0] A_COUNT  = 3'd0;
  localparam logic [2:0] A_CEIL   = 3'd1;
  localparam logic [2:0] A_MODE   = 3'd2;
  localparam logic [2:0] A_CTRL   = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;
  localparam logic [2:0] A_START  = 3'd5;

  // clear-source code selecting the ceiling
  localparam logic [2:0] CLR_CEIL = 3'd1;
  localparam int         DIR_BIT  = 7;
endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic cur_o,
  output logic prev_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      prev_o <= 1'b0;
    end else begin
      sr     <= {sr[STAGES-2:0], din};
      prev_o <= sr[STAGES-1];
    end
  end

  assign cur_o = sr[STAGES-1];
endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
  import qpc_pkg::*;
(
  input  logic [3:0] mode,
  input  logic       a_cur,
  input  logic       a_prev,
  input  logic       b_cur,
  input  logic       b_prev,
  output logic       step_o,
  output logic       up_o
);
  logic a_chg, b_chg;
  assign a_chg = a_cur ^ a_prev;
  assign b_chg = b_cur ^ b_prev;

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b0;
    case (mode)
      MODE_X4: begin
        step_o = a_chg ^ b_chg;
        up_o   = a_cur ^ b_prev;
      end
      MODE_PD: begin
        step_o = a_cur & ~a_prev;
        up_o   = b_cur;
      end
      MODE_X2B: begin
        step_o = b_chg;
        up_o   = ~(a_cur ^ b_cur);
      end
      default: begin
        step_o = 1'b0;
        up_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             step,
  input  logic             up,
  input  logic             enable,
  input  logic [CNT_W-1:0] ceil,
  input  logic             clr_on_ceil,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             taken_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] next_val(
    input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] lim,
    input logic go_up, input logic use_lim);
    if (go_up)
      next_val = (use_lim && c == lim) ? '0 : c + 1'b1;
    else if (c == '0)
      next_val = use_lim ? lim : TOP;
    else
      next_val = c - 1'b1;
  endfunction

  assign taken_o = step & enable & ~wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      dir_o <= 1'b0;
    end else begin
      if (wr_en)        cnt_o <= wr_data;
      else if (taken_o) cnt_o <= next_val(cnt_o, ceil, up, clr_on_ceil);
      if (taken_o)      dir_o <= up;
    end
  end

  // R6
  ceil_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && up && clr_on_ceil && cnt_o == ceil) |=> (cnt_o == '0));
  // R7
  down_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && !up && clr_on_ceil && cnt_o == '0) |=> (cnt_o == $past(ceil)));
  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_en) |=> $stable(cnt_o));
  // R11
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_o == $past(wr_data)));
  // R8
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |=> $stable(dir_o));
endmodule

// File: rtl/quad_phase_counter.sv
module quad_phase_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_CH      = 3,
  parameter int CH_INDEX    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_up_o
);
  localparam logic [7:0] MODE_RST = {4'd0, MODE_X4};
  localparam logic [7:0] CTRL_RST = {5'd0, CLR_CEIL};

  logic [CNT_W-1:0]  ceil_r;
  logic [7:0]        mode_r, ctrl_r;
  logic [NUM_CH-1:0] start_r;

  // synchronised encoder lines: index 0 = A, 1 = B
  logic [1:0] enc_in, enc_cur, enc_prev;
  assign enc_in = {enc_b, enc_a};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    qpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(enc_in[i]),
      .cur_o(enc_cur[i]), .prev_o(enc_prev[i]));
  end

  logic step_w, up_w, taken_w, cnt_wr;

  qpc_decoder u_dec (
    .mode(mode_r[3:0]),
    .a_cur(enc_cur[0]), .a_prev(enc_prev[0]),
    .b_cur(enc_cur[1]), .b_prev(enc_prev[1]),
    .step_o(step_w), .up_o(up_w));

  assign cnt_wr = reg_we && (reg_addr == A_COUNT);

  qpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cnt_wr), .wr_data(reg_wdata),
    .step(step_w), .up(up_w), .enable(start_r[CH_INDEX]),
    .ceil(ceil_r), .clr_on_ceil(ctrl_r[2:0] == CLR_CEIL),
    .cnt_o(count_o), .dir_o(dir_up_o), .taken_o(taken_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_r  <= '1;
      mode_r  <= MODE_RST;
      ctrl_r  <= CTRL_RST;
      start_r <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CEIL:  ceil_r  <= reg_wdata;
        A_MODE:  mode_r  <= reg_wdata[7:0];
        A_CTRL:  ctrl_r  <= reg_wdata[7:0];
        A_START: start_r <= reg_wdata[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_COUNT:  reg_rdata = count_o;
      A_CEIL:   reg_rdata = ceil_r;
      A_MODE:   reg_rdata[7:0] = mode_r;
      A_CTRL:   reg_rdata[7:0] = ctrl_r;
      A_STATUS: reg_rdata[DIR_BIT] = dir_up_o;
      A_START:  reg_rdata[NUM_CH-1:0] = start_r;
      default:  reg_rdata = '0;
    endcase
  end

  // R4
  pd_a_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r[3:0] == MODE_PD && step_w) |-> $rose(enc_cur[0]));
  // R5
  x2b_b_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r[3:0] == MODE_X2B && step_w) |-> !$stable(enc_cur[1]));
  // R10
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r[3:0] != MODE_X4 && mode_r[3:0] != MODE_PD && mode_r[3:0] != MODE_X2B)
      |-> !step_w);
  // R3
  x4_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r[3:0] == MODE_X4 && step_w) |-> $countones(enc_cur ^ enc_prev) == 1);
endmodule

// File: tb/quad_phase_counter_tb.sv
module quad_phase_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 1;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata, count_o;
  logic dir_up_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_phase_counter u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count_o(count_o), .dir_up_o(dir_up_o));

  // ---------------- behavioural reference ----------------
  int m_cnt, m_ceil, m_mode, m_ctrl, m_start, m_dir;
  bit sa1, sa2, pa, sb1, sb2, pb;

  function automatic int gidx(bit a, bit b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ceil = 16'hFFFF; m_mode = 4; m_ctrl = 1; m_start = 0; m_dir = 0;
      sa1 = 0; sa2 = 0; pa = 0; sb1 = 0; sb2 = 0; pb = 0;
    end else begin
      bit ev, up;
      int d;
      ev = 0; up = 0;
      if (((m_start >> CH) & 1) == 1) begin
        case (m_mode % 16)
          4: begin
            d = (gidx(sa2, sb2) - gidx(pa, pb) + 4) % 4;
            if (d == 1) begin ev = 1; up = 1; end
            if (d == 3) begin ev = 1; up = 0; end
          end
          5: if (sa2 && !pa) begin ev = 1; up = sb2; end
          7: if (sb2 != pb) begin ev = 1; up = (sa2 == sb2); end
          default: ev = 0;
        endcase
      end
      if (reg_we && reg_addr == 3'd0) m_cnt = reg_wdata;
      else if (ev) begin
        if (up) m_cnt = ((m_ctrl % 8) == 1 && m_cnt == m_ceil) ? 0 : (m_cnt + 1) % 65536;
        else if (m_cnt == 0) m_cnt = ((m_ctrl % 8) == 1) ? m_ceil : 65535;
        else m_cnt = m_cnt - 1;
        m_dir = up;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd1: m_ceil = reg_wdata;
          3'd2: m_mode = reg_wdata % 256;
          3'd3: m_ctrl = reg_wdata % 256;
          3'd5: m_start = reg_wdata % (1 << NCH);
          default: ;
        endcase
      end
      pa = sa2; sa2 = sa1; sa1 = enc_a;
      pb = sb2; sb2 = sb1; sb1 = enc_b;
    end
  end

  // every-cycle comparison (R12 timing, all modes)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (count_o != m_cnt[15:0] || dir_up_o != m_dir[0]) begin
        fails++;
        $display("FAIL R12 model cnt=%0d dir=%0d expected cnt=%0d dir=%0d",
                 count_o, dir_up_o, m_cnt, m_dir);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    reg_we = 1; reg_addr = addr[2:0]; reg_wdata = data[15:0];
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int addr, output int val);
    @(negedge clk);
    reg_addr = addr[2:0];
    #1 val = reg_rdata;
  endtask

  task automatic set_ab(bit a, bit b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  int qpos = 0;
  task automatic qstep(bit fwd, int n);
    for (int i = 0; i < n; i++) begin
      qpos = fwd ? (qpos + 1) % 4 : (qpos + 3) % 4;
      case (qpos)
        0: set_ab(0, 0);
        1: set_ab(1, 0);
        2: set_ab(1, 1);
        default: set_ab(0, 1);
      endcase
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 R6 R8 R9 reset state
    chk("R1 reset count", count_o, 0);
    rd(1, v); chk("R6 reset ceiling", v, 16'hFFFF);
    rd(2, v); chk("R2 reset mode", v, 4);
    rd(3, v); chk("R6 reset control", v, 1);
    rd(5, v); chk("R9 reset start", v, 0);
    chk("R8 reset dir", dir_up_o, 0);

    // R9 disabled: no counting
    qstep(1, 4);
    chk("R9 hold while stopped", count_o, 0);

    wr(5, 1 << CH);
    // R3 x4 forward / backward
    qstep(1, 8);
    chk("R3 x4 forward", count_o, 8);
    chk("R8 dir up", dir_up_o, 1);
    qstep(0, 3);
    chk("R3 x4 backward", count_o, 5);
    rd(4, v); chk("R8 status down", v, 0);
    wr(4, 16'h0080);
    rd(4, v); chk("R8 status write ignored", v, 0);

    // R6/R7 ceiling clear
    wr(1, 9);
    wr(0, 9);
    rd(0, v); chk("R1 count readback", v, 9);
    qstep(1, 1);
    chk("R6 clear at ceiling", count_o, 0);
    qstep(0, 1);
    chk("R7 down from zero loads ceiling", count_o, 9);

    // free-running wrap
    wr(3, 0);
    wr(0, 9);
    qstep(1, 1);
    chk("R6 no clear when not selected", count_o, 10);
    wr(0, 0);
    qstep(0, 1);
    chk("R7 down from zero wraps full", count_o, 16'hFFFF);

    // R4 step/direction
    wr(3, 1); wr(1, 16'hFFFF); wr(2, 5); wr(0, 100);
    set_ab(0, 1); chk("R4 A fall ignored", count_o, 100);
    set_ab(1, 1); chk("R4 A rise B high up", count_o, 101);
    set_ab(0, 1); chk("R4 A fall no count", count_o, 101);
    set_ab(0, 0); chk("R4 B edge ignored", count_o, 101);
    set_ab(1, 0); chk("R4 A rise B low down", count_o, 100);

    // R5 x2 on B
    wr(2, 7); wr(0, 50);
    set_ab(0, 0); chk("R5 A edge ignored", count_o, 50);
    set_ab(1, 0); chk("R5 A edge ignored again", count_o, 50);
    set_ab(1, 1); chk("R5 B rise A high up", count_o, 51);
    set_ab(0, 1); chk("R5 A fall ignored", count_o, 51);
    set_ab(0, 0); chk("R5 B fall A low up", count_o, 52);
    set_ab(0, 1); chk("R5 B rise A low down", count_o, 51);

    // R10 unsupported mode
    wr(2, 6); wr(0, 7);
    set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    chk("R10 mode 6 holds", count_o, 7);
    wr(2, 9);
    set_ab(1, 0); set_ab(0, 0);
    chk("R10 mode 9 holds", count_o, 7);

    // R2 high nibble ignored
    wr(2, 8'h14);
    set_ab(1, 0);
    chk("R2 mode 0x14 decodes as x4", count_o, 8);

    // R11 write wins over coincident event
    @(negedge clk); enc_b = 1;
    @(negedge clk);
    @(negedge clk);
    reg_we = 1; reg_addr = 3'd0; reg_wdata = 16'd300;
    @(negedge clk); reg_we = 0;
    repeat (3) @(negedge clk);
    chk("R11 write wins", count_o, 300);

    // R12 latency: change seen after third edge
    @(negedge clk); enc_a = 0;
    @(negedge clk); chk("R12 no change after 1 edge", count_o, 300);
    @(negedge clk); chk("R12 no change after 2 edges", count_o, 300);
    @(negedge clk); chk("R12 change after 3 edges", count_o, 301);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule